// File: doc/BRIEF.md
# Windowed Oscillator Edge Qualifier

This block cleans up an external oscillator signal by timing it against a faster reference clock. The raw input is synchronized into the reference domain. The block then counts reference cycles from one accepted oscillator transition to the next. A transition is taken only when its count falls inside a narrow window centred on a programmed half-period count. Transitions that arrive early are dropped. If no transition arrives by the end of the window, the block reports a missing edge, and the next transition is taken as a fresh reference. The filtered output toggles only on accepted transitions. A status flag reports that the oscillator is qualified once enough accepted transitions have come in a row.

An 8-bit configuration register holds three fields: an enable, a window-width select and the expected half-period count. The half-period count is the reference-to-oscillator frequency ratio divided by two. A count of zero turns the filter off, and the synchronized input then goes straight to the output. A write is honoured only while the protect input is low and the clock-select input is high. An honoured write restarts qualification and pulses an output that clears an external lock status. Control and status pins are plain levels. No data stream crosses the block boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `osc_edge_qualifier`

## Requirements
- R1: After reset, `cfg_rdata` is 0, and `osc_out`, `osc_qual` and `lock_clr` are all 0.
- R2: The register layout is: bit 7 is the enable, bit 6 is the wide-window select, bits 4:0 are the half-period count, and bit 5 always reads 0. A write is visible on `cfg_rdata` one cycle after the write cycle.
- R3: A write strobe while `wr_protect` is 1 or `clk_sel` is 0 is ignored. The register keeps its value and `lock_clr` stays low.
- R4: An honoured write drives `lock_clr` high for exactly the one cycle after the write cycle, and `osc_qual` is 0 in that cycle.
- R5: With bit 6 at 0, a transition is accepted only when the measured gap equals the half-period count N. The gap is the number of reference cycles since the last accepted or reference transition.
- R6: With bit 6 at 1, a transition is accepted when the gap is N-1, N or N+1.
- R7: A transition whose gap lies below the window is discarded. Counting then continues from the last accepted transition.
- R8: If the gap passes the end of the window (N for narrow, N+1 for wide), `osc_qual` drops. The next transition becomes a new reference and does not toggle the output. The first transition after enabling or after a write is also a reference only.
- R9: `osc_qual` rises on the 16th consecutive accepted transition and not before.
- R10: With filtering on, `osc_out` toggles only for accepted transitions, three reference cycles after the input changes.
- R11: With the half-period count at 0, `osc_out` follows `osc_in` two cycles late. Every transition counts toward the 16 needed by `osc_qual`.
- R12: While bit 7 is 0, `osc_out` and `osc_qual` are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read-back |
| wr_protect | input | 1 | Write protect; 1 blocks writes |
| clk_sel | input | 1 | Clock-select state; writes need 1 |
| osc_in | input | 1 | Raw oscillator input, asynchronous |
| osc_out | output | 1 | Filtered oscillator output |
| osc_qual | output | 1 | Oscillator qualified flag |
| lock_clr | output | 1 | One-cycle pulse that clears external lock status |

## Verification
Results are due at fixed delays:
- `cfg_rdata` and `lock_clr` change one cycle after the write cycle.
- In pass-through mode, `osc_out` changes two cycles after `osc_in`.
- With filtering on, `osc_out` and `osc_qual` change three cycles after the input transition. That is two synchronizer stages and then the accept register.

The bench drives every input on the falling edge. It reads results on the falling edge reached after exactly that many rising edges. For the latency case it also checks that the earlier falling edges still show the old value. Toggles are counted by a monitor that samples a fixed delay after each rising edge. Each sweep run waits three cycles after its last input change before it compares the toggle count and the flag against an arithmetic model of the gaps.

// File: rtl/oeq_pkg.sv
package oeq_pkg;
  localparam int CFG_W      = 8;
  localparam int FILT_W     = 5;
  localparam int EN_BIT     = 7;
  localparam int WIDE_BIT   = 6;
  localparam int PAD_W      = CFG_W - 2 - FILT_W;
  localparam int GAP_W      = FILT_W + 1;
  localparam int QUAL_COUNT = 16;

  typedef struct packed {
    logic              en;
    logic              wide;
    logic [FILT_W-1:0] ratio;
  } qcfg_t;
endpackage

// File: rtl/oeq_cfg_reg.sv
module oeq_cfg_reg
  import oeq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [CFG_W-1:0] wdata,
  input  logic             protect,
  input  logic             sel_ok,
  output qcfg_t            cfg,
  output logic [CFG_W-1:0] rdata,
  output logic             wr_take,
  output logic             clr_pulse
);
  assign wr_take = wr_stb && !protect && sel_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= '0;
      clr_pulse <= 1'b0;
    end else begin
      clr_pulse <= wr_take;
      if (wr_take) begin
        cfg.en    <= wdata[EN_BIT];
        cfg.wide  <= wdata[WIDE_BIT];
        cfg.ratio <= wdata[FILT_W-1:0];
      end
    end
  end

  assign rdata = {cfg.en, cfg.wide, {PAD_W{1'b0}}, cfg.ratio};

  // R3
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_stb && (protect || !sel_ok)) |-> (cfg == $past(cfg)));
endmodule

// File: rtl/oeq_sync.sv
module oeq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic change
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] pipe;
  logic         held;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[TOP-1:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= pipe[TOP];
  end

  assign level  = pipe[TOP];
  assign change = pipe[TOP] ^ held;
endmodule

// File: rtl/oeq_window.sv
module oeq_window
  import oeq_pkg::*;
#(
  parameter int CNT_W   = GAP_W,
  parameter int QUAL_NB = QUAL_COUNT
) (
  input  logic  clk,
  input  logic  rst_n,
  input  qcfg_t cfg,
  input  logic  restart,
  input  logic  osc_edge,
  output logic  tog,
  output logic  qual,
  output logic  accept
);
  localparam int STRK_W = $clog2(QUAL_NB + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [STRK_W-1:0] STRK_TOP = STRK_W'(QUAL_NB);

  logic [CNT_W-1:0]  cnt, ratio_x, lo, hi;
  logic [STRK_W-1:0] streak, streak_nxt;
  logic              trk, bypass, late, in_win, reref, live;

  assign ratio_x    = CNT_W'(cfg.ratio);
  assign lo         = (cfg.wide && ratio_x != '0) ? ratio_x - 1'b1 : ratio_x;
  assign hi         = cfg.wide ? ratio_x + 1'b1 : ratio_x;
  assign bypass     = (cfg.ratio == '0);
  assign late       = cnt > hi;
  assign in_win     = (cnt >= lo) && !late;
  assign live       = cfg.en && !restart;
  assign accept     = live && osc_edge && (bypass || (trk && in_win));
  assign reref      = live && !bypass && osc_edge && (!trk || late);
  assign streak_nxt = (streak == STRK_TOP) ? streak : streak + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      trk    <= 1'b0;
      tog    <= 1'b0;
      qual   <= 1'b0;
      streak <= '0;
    end else if (!live) begin
      cnt    <= '0;
      trk    <= 1'b0;
      qual   <= 1'b0;
      streak <= '0;
      if (!cfg.en) tog <= 1'b0;
    end else if (accept) begin
      cnt    <= CNT_W'(1);
      tog    <= ~tog;
      streak <= streak_nxt;
      if (streak_nxt == STRK_TOP) qual <= 1'b1;
    end else if (reref) begin
      cnt    <= CNT_W'(1);
      trk    <= 1'b1;
      qual   <= 1'b0;
      streak <= '0;
    end else if (trk && late) begin
      trk    <= 1'b0;
      qual   <= 1'b0;
      streak <= '0;
    end else if (trk && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R12
  off_holds_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg.en) |-> (!qual && !tog));

  // R10
  toggle_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tog != $past(tog)) && $past(cfg.en)) |-> $past(accept));

  // R9
  qual_rise_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual) |-> $past(accept));

  // R8
  window_end_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trk |-> (cnt <= hi + 1'b1));
endmodule

// File: rtl/osc_edge_qualifier.sv
module osc_edge_qualifier
  import oeq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_EDGES  = QUAL_COUNT
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             wr_protect,
  input  logic             clk_sel,
  input  logic             osc_in,
  output logic             osc_out,
  output logic             osc_qual,
  output logic             lock_clr
);
  qcfg_t cfg;
  logic  wr_take, sync_lvl, sync_chg, tog, accept;

  oeq_cfg_reg u_cfg (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .wr_stb    (cfg_wr),
    .wdata     (cfg_wdata),
    .protect   (wr_protect),
    .sel_ok    (clk_sel),
    .cfg       (cfg),
    .rdata     (cfg_rdata),
    .wr_take   (wr_take),
    .clr_pulse (lock_clr)
  );

  oeq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .din    (osc_in),
    .level  (sync_lvl),
    .change (sync_chg)
  );

  oeq_window #(.CNT_W(GAP_W), .QUAL_NB(QUAL_EDGES)) u_win (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .cfg      (cfg),
    .restart  (wr_take),
    .osc_edge (sync_chg),
    .tog      (tog),
    .qual     (osc_qual),
    .accept   (accept)
  );

  always_comb begin
    if (!cfg.en)              osc_out = 1'b0;
    else if (cfg.ratio == '0) osc_out = sync_lvl;
    else                      osc_out = tog;
  end

  // R4
  clear_drops_qual_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    lock_clr |-> !osc_qual);
endmodule

// File: tb/osc_edge_qualifier_test.sv
module osc_edge_qualifier_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       wr_protect = 1'b0;
  logic       clk_sel = 1'b1;
  logic       osc_in = 1'b0;
  logic       osc_out, osc_qual, lock_clr;

  int tests = 0;
  int fails = 0;
  int tog_seen = 0;
  int lock_seen = 0;
  logic prev_out = 1'b0;

  always #5 clk = ~clk;

  osc_edge_qualifier uut (
    .clk_ref(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .wr_protect(wr_protect), .clk_sel(clk_sel),
    .osc_in(osc_in), .osc_out(osc_out), .osc_qual(osc_qual), .lock_clr(lock_clr)
  );

  always begin
    @(posedge clk);
    #2;
    if (osc_out !== prev_out) tog_seen++;
    prev_out = osc_out;
    if (lock_clr === 1'b1) lock_seen++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic prot, input logic sel);
    cfg_wdata  = d;
    wr_protect = prot;
    clk_sel    = sel;
    cfg_wr     = 1'b1;
    @(negedge clk);
    cfg_wr     = 1'b0;
    wr_protect = 1'b0;
    clk_sel    = 1'b1;
  endtask

  task automatic flip(input int gap);
    osc_in = ~osc_in;
    repeat (gap) @(negedge clk);
  endtask

  task automatic sweep(input int n, input bit wide, input int kind);
    int lo, hi, c, cp, streak, exp_tog, base, g;
    bit acq, exp_q;
    lo = (wide && n > 0) ? n - 1 : n;
    hi = wide ? n + 1 : n;
    wr({1'b1, wide, 1'b0, 5'(n)}, 1'b0, 1'b1);
    @(negedge clk);
    base = tog_seen;
    acq = 1; c = 0; streak = 0; exp_tog = 0; exp_q = 0;
    for (int i = 0; i < 20; i++) begin
      g = (kind < 7) ? n + kind - 3 : ((i % 2) ? n + 1 : n - 1);
      if (g < 1) g = 1;
      if (i > 0) begin
        repeat (g) @(negedge clk);
        if (acq) begin acq = 0; c = 0; end
        else begin
          cp = c + g;
          if (cp > hi) begin c = 0; streak = 0; exp_q = 0; end
          else if (cp >= lo) begin
            c = 0; exp_tog++; streak++;
            if (streak >= 16) exp_q = 1;
          end else c = cp;
        end
      end else begin
        acq = 0; c = 0;
      end
      osc_in = ~osc_in;
    end
    repeat (3) @(negedge clk);
    // R5 R6 R7 R8 R10: toggle count from windowed acceptance
    check(tog_seen - base == exp_tog, wide ? "R6 R7 R8 wide toggles" : "R5 R7 R8 narrow toggles",
          tog_seen - base, exp_tog);
    // R9 R8: qualified flag
    check(osc_qual == exp_q, "R9 R8 qual after sweep", int'(osc_qual), int'(exp_q));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int ls, bt;
    bit ok;
    repeat (3) @(negedge clk);
    // R1
    check(cfg_rdata == 8'h00, "R1 rdata", cfg_rdata, 0);
    check(osc_out == 0 && osc_qual == 0 && lock_clr == 0, "R1 outputs",
          {osc_out, osc_qual, lock_clr}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 blocked writes
    ls = lock_seen;
    wr(8'hFF, 1'b1, 1'b1);
    check(cfg_rdata == 8'h00, "R3 protect blocks", cfg_rdata, 0);
    wr(8'hFF, 1'b0, 1'b0);
    @(negedge clk);
    check(cfg_rdata == 8'h00, "R3 clk_sel blocks", cfg_rdata, 0);
    check(lock_seen == ls, "R3 no lock clear", lock_seen - ls, 0);

    // R2 R4 honoured write
    wr(8'hFF, 1'b0, 1'b1);
    check(cfg_rdata == 8'hDF, "R2 layout bit5 zero", cfg_rdata, 8'hDF);
    check(lock_clr == 1'b1, "R4 lock pulse", lock_clr, 1);
    @(negedge clk);
    check(lock_clr == 1'b0, "R4 single pulse", lock_clr, 0);

    // R12 disabled
    wr(8'h04, 1'b0, 1'b1);
    check(cfg_rdata == 8'h04, "R2 readback", cfg_rdata, 8'h04);
    ok = 1;
    for (int i = 0; i < 10; i++) begin
      flip(4);
      if (osc_out !== 1'b0 || osc_qual !== 1'b0) ok = 0;
    end
    check(ok, "R12 held low while disabled", int'(ok), 1);

    // R11 pass-through
    wr(8'h80, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    bt = tog_seen;
    osc_in = ~osc_in;
    @(negedge clk);
    check(osc_out != osc_in, "R11 not yet after 1 cycle", osc_out, !osc_in);
    @(negedge clk);
    check(osc_out == osc_in, "R11 follows after 2 cycles", osc_out, osc_in);
    @(negedge clk);
    for (int i = 0; i < 19; i++) flip(3);
    check(tog_seen - bt == 20, "R11 every edge passes", tog_seen - bt, 20);
    check(osc_qual == 1'b1, "R11 qual in pass-through", osc_qual, 1);

    // R10 R9 latency and 16-edge threshold, N=8 narrow
    wr(8'h88, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    bt = tog_seen;
    osc_in = ~osc_in;
    for (int i = 0; i < 14; i++) begin
      repeat (8) @(negedge clk);
      osc_in = ~osc_in;
    end
    repeat (8) @(negedge clk);
    osc_in = ~osc_in;
    ls = tog_seen;
    repeat (2) @(negedge clk);
    check(tog_seen == ls, "R10 no toggle before 3 cycles", tog_seen - ls, 0);
    @(negedge clk);
    check(tog_seen == ls + 1, "R10 toggle at 3 cycles", tog_seen - ls, 1);
    check(osc_qual == 1'b0, "R9 not qualified at 15", osc_qual, 0);
    repeat (5) @(negedge clk);
    osc_in = ~osc_in;
    repeat (3) @(negedge clk);
    check(osc_qual == 1'b1, "R9 qualified at 16", osc_qual, 1);
    check(tog_seen - bt == 16, "R5 exact gaps accepted", tog_seen - bt, 16);
    wr(8'h88, 1'b0, 1'b1);
    check(osc_qual == 1'b0 && lock_clr == 1'b1, "R4 write clears qual",
          {osc_qual, lock_clr}, 1);
    repeat (3) @(negedge clk);

    // sweeps R5 R6 R7 R8
    for (int k = 1; k <= 13; k++) begin
      for (int w = 0; w < 2; w++) begin
        for (int kind = 0; kind < 8; kind++) begin
          int n;
          n = (k == 13) ? 31 : k;
          sweep(n, w[0], kind);
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule